// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block holds the mode word of an SDRAM controller and turns each burst request into a stream of column addresses, one per clock. A mode word is written through a load port. It is stored only when the accompanying bank-select value is zero. The stored word is decoded into four settings: burst length, burst ordering, write-burst behaviour and CAS latency. Any reserved setting raises an illegal-mode flag.

A start request carries a starting column and a read/write flag. On the next clock the block begins to emit addresses. Each address comes with a valid flag, and the final beat of a fixed-length burst also carries a last flag.

Fixed-length bursts stay inside an aligned block of columns, and the low column bits step in either sequential or interleaved order. A full-page burst walks the whole row, wraps at the row end, and runs until a terminate input stops it. A new start request during a burst abandons the old one. A write-single setting makes every write a one-beat burst, while reads keep the programmed length.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset no address is valid, the illegal flag is 0, and the mode word is 0x020: length 1, sequential, CAS latency 2, writes follow the burst length.
- R2: A mode load is stored only when mode_bank_i is 0. A load with any other bank value leaves the stored mode and all outputs unchanged.
- R3: cas_lat_o is 2 when bits [6:4] are 010 and 3 when they are 011. It is 0 whenever the illegal flag is set.
- R4: mode_illegal_o is 1 when any of the following holds: bits [2:0] are not one of 000, 001, 010, 011, 111; bits [2:0] are 111 with bit 3 set; bits [6:4] are not 010 or 011; bits [8:7] are nonzero; bits [11:10] are nonzero.
- R5: While mode_illegal_o is 1, start_i is ignored and no burst begins.
- R6: An accepted start makes col_valid_o high on the next clock, with col_o equal to start_col_i. One address follows per clock after that.
- R7: With bit 3 = 0 (sequential) and a burst length L of 2, 4 or 8 (bits [2:0] = 001, 010, 011), beat i has column base + ((start mod L) + i) mod L, where base is start rounded down to a multiple of L.
- R8: With bit 3 = 1 (interleaved), beat i has column base + ((start mod L) XOR i).
- R9: col_last_o is high exactly on beat L-1 of a fixed-length burst. On the next clock col_valid_o is low unless a new start was accepted.
- R10: Bits [2:0] = 111 with bit 3 = 0 give a full-page burst. Its columns increment by one, wrap from the top column to 0, never raise col_last_o, and continue until terminated.
- R11: term_i during a burst makes col_valid_o low on the next clock, unless a start is accepted in the same cycle.
- R12: With bit 9 = 1, a write start (start_wr_i = 1) gives a single beat with col_last_o high. Reads keep the programmed length. With bit 9 = 0, writes use the programmed length.
- R13: A start accepted during a burst abandons it, and the new burst's first column appears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Mode word load strobe |
| mode_bank_i | input | 2 | Bank-select value with the load; 0 selects the mode register |
| mode_word_i | input | 12 | Mode word to store |
| start_i | input | 1 | Burst start request |
| start_col_i | input | COL_W | Starting column of the burst |
| start_wr_i | input | 1 | 1 for a write burst, 0 for a read |
| term_i | input | 1 | Stop the current burst |
| col_o | output | COL_W | Column address of the current beat |
| col_valid_o | output | 1 | col_o holds a beat |
| col_last_o | output | 1 | Final beat of a fixed-length burst |
| cas_lat_o | output | 2 | Decoded CAS latency, 0 when the mode is illegal |
| mode_illegal_o | output | 1 | Stored mode word holds a reserved setting |

## Verification
On every cycle the assertions check the following:
- the CAS latency output agrees with the illegal flag;
- a last flag never appears without a valid beat;
- the valid flag drops after a last beat or a terminate;
- an accepted start puts its column out on the next clock;
- an illegal mode blocks starts;
- a load to a nonzero bank leaves the decoded outputs unchanged.

Only the bench scenarios can show the exact beat-by-beat column orders, because these depend on the mode word and the start offset together. The same holds for the block wrap of sequential and interleaved bursts, the page wrap of full-page bursts, the split between read and write lengths under write-single mode, and which reserved codes set the flag.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  localparam int MODE_W = 12;
  localparam int OFF_W  = 3;  // low column bits used by an 8-beat block

  localparam logic [MODE_W-1:0] MODE_RST = 12'h020;

  typedef struct packed {
    logic [OFF_W-1:0] blk_mask;   // burst length minus one
    logic             full_page;
    logic             interleave;
    logic             wr_single;
    logic [1:0]       cas_lat;
    logic             illegal;
  } mode_dec_t;

  function automatic logic [OFF_W-1:0] code_to_mask(input logic [1:0] code);
    logic [OFF_W:0] t;
    t = ({{OFF_W{1'b0}}, 1'b1} << code) - 1'b1;
    return t[OFF_W-1:0];
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import sdram_colgen_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [MODE_W-1:0]    word_i,
  output mode_dec_t            dec_o
);

  logic [MODE_W-1:0] word_q;
  logic [2:0]        bl;
  logic              bl_ok, cas_ok, op_ok, hi_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      word_q <= MODE_RST;
    else if (load_i && bank_i == '0)  word_q <= word_i;
  end

  always_comb begin
    bl     = word_q[2:0];
    bl_ok  = (bl[2] == 1'b0) || (bl == 3'b111 && !word_q[3]);
    cas_ok = (word_q[6:5] == 2'b01);
    op_ok  = (word_q[8:7] == 2'b00);
    hi_ok  = (word_q[11:10] == 2'b00);

    dec_o.blk_mask   = code_to_mask(bl[1:0]);
    dec_o.full_page  = (bl == 3'b111);
    dec_o.interleave = word_q[3];
    dec_o.wr_single  = word_q[9];
    dec_o.cas_lat    = {1'b1, word_q[4]};
    dec_o.illegal    = !(bl_ok && cas_ok && op_ok && hi_ok);
  end

endmodule

// File: rtl/colgen_burst_ctl.sv
module colgen_burst_ctl
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mode_dec_t          dec_i,
  input  logic               start_i,
  input  logic [COL_W-1:0]   start_col_i,
  input  logic               start_wr_i,
  input  logic               term_i,
  output logic               active_o,
  output logic               full_o,
  output logic               ilv_o,
  output logic [OFF_W-1:0]   mask_o,
  output logic [COL_W-1:0]   col0_o,
  output logic [COL_W-1:0]   cnt_o,
  output logic               last_o
);

  logic             accept, single;
  logic             active_q, full_q, ilv_q;
  logic [OFF_W-1:0] mask_q;
  logic [COL_W-1:0] col0_q, cnt_q;

  assign accept = start_i && !dec_i.illegal;
  assign single = start_wr_i && dec_i.wr_single;
  assign last_o = active_q && !full_q && (cnt_q[OFF_W-1:0] == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      mask_q   <= '0;
      col0_q   <= '0;
      cnt_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      full_q   <= dec_i.full_page && !single;
      ilv_q    <= dec_i.interleave;
      mask_q   <= single ? '0 : dec_i.blk_mask;
      col0_q   <= start_col_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (term_i || last_o) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign full_o   = full_q;
  assign ilv_o    = ilv_q;
  assign mask_o   = mask_q;
  assign col0_o   = col0_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic               full_i,
  input  logic               ilv_i,
  input  logic [OFF_W-1:0]   mask_i,
  input  logic [COL_W-1:0]   col0_i,
  input  logic [COL_W-1:0]   cnt_i,
  output logic [COL_W-1:0]   col_o
);

  logic [OFF_W-1:0] off_seq, off_ilv, off_sel;
  logic [COL_W-1:0] blk_col, page_col;

  assign off_seq  = col0_i[OFF_W-1:0] + cnt_i[OFF_W-1:0];
  assign off_ilv  = col0_i[OFF_W-1:0] ^ cnt_i[OFF_W-1:0];
  assign off_sel  = ilv_i ? off_ilv : off_seq;
  assign page_col = col0_i + cnt_i;

  // masked low bits step, unmasked low bits and upper bits hold the block
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < OFF_W) begin : g_low
      assign blk_col[b] = mask_i[b] ? off_sel[b] : col0_i[b];
    end else begin : g_high
      assign blk_col[b] = col0_i[b];
    end
  end

  assign col_o = full_i ? page_col : blk_col;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_load_i,
  input  logic [BANK_W-1:0]  mode_bank_i,
  input  logic [MODE_W-1:0]  mode_word_i,
  input  logic               start_i,
  input  logic [COL_W-1:0]   start_col_i,
  input  logic               start_wr_i,
  input  logic               term_i,
  output logic [COL_W-1:0]   col_o,
  output logic               col_valid_o,
  output logic               col_last_o,
  output logic [1:0]         cas_lat_o,
  output logic               mode_illegal_o
);

  mode_dec_t        dec;
  logic             active, full, ilv;
  logic [OFF_W-1:0] mask;
  logic [COL_W-1:0] col0, cnt;

  colgen_mode_reg #(.BANK_W(BANK_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .bank_i (mode_bank_i),
    .word_i (mode_word_i),
    .dec_o  (dec)
  );

  colgen_burst_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_i       (dec),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .start_wr_i  (start_wr_i),
    .term_i      (term_i),
    .active_o    (active),
    .full_o      (full),
    .ilv_o       (ilv),
    .mask_o      (mask),
    .col0_o      (col0),
    .cnt_o       (cnt),
    .last_o      (col_last_o)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .full_i (full),
    .ilv_i  (ilv),
    .mask_i (mask),
    .col0_i (col0),
    .cnt_i  (cnt),
    .col_o  (col_o)
  );

  assign col_valid_o    = active;
  assign mode_illegal_o = dec.illegal;
  assign cas_lat_o      = dec.illegal ? 2'd0 : dec.cas_lat;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_load_i,
  input logic [BANK_W-1:0]  mode_bank_i,
  input logic [11:0]        mode_word_i,
  input logic               start_i,
  input logic [COL_W-1:0]   start_col_i,
  input logic               start_wr_i,
  input logic               term_i,
  input logic [COL_W-1:0]   col_o,
  input logic               col_valid_o,
  input logic               col_last_o,
  input logic [1:0]         cas_lat_o,
  input logic               mode_illegal_o
);

  logic go;
  assign go = start_i && !mode_illegal_o;

  a_r3_cas_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_illegal_o |-> (cas_lat_o == 2'd2 || cas_lat_o == 2'd3));

  a_r3_cas_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_illegal_o |-> cas_lat_o == 2'd0);

  a_r2_bank_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_load_i && mode_bank_i != '0) |=> ($stable(mode_illegal_o) && $stable(cas_lat_o)));

  a_r5_illegal_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!col_valid_o && start_i && mode_illegal_o) |=> !col_valid_o);

  a_r6_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (col_valid_o && col_o == $past(start_col_i)));

  a_r9_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_last_o |-> col_valid_o);

  a_r9_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && col_last_o && !go) |=> !col_valid_o);

  a_r11_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && term_i && !go) |=> !col_valid_o);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb;

  localparam int COL_W = 9;

  typedef struct packed {
    logic [11:0]      mode;
    logic [COL_W-1:0] col;
    logic             wr;
    logic [3:0]       len;
  } vec_t;

  // R7 seq, R8 interleaved, R6 single, R12 write-single split
  localparam vec_t VECS [9] = '{
    '{12'h023, 9'h01D, 1'b0, 4'd8},
    '{12'h03B, 9'h01D, 1'b0, 4'd8},
    '{12'h032, 9'h046, 1'b0, 4'd4},
    '{12'h029, 9'h0F3, 1'b0, 4'd2},
    '{12'h020, 9'h1FF, 1'b0, 4'd1},
    '{12'h222, 9'h10B, 1'b0, 4'd4},
    '{12'h222, 9'h10B, 1'b1, 4'd1},
    '{12'h022, 9'h10B, 1'b1, 4'd4},
    '{12'h03A, 9'h107, 1'b0, 4'd4}
  };

  logic             clk_i = 0, rst_ni = 0;
  logic             mode_load_i = 0, start_i = 0, start_wr_i = 0, term_i = 0;
  logic [1:0]       mode_bank_i = 0;
  logic [11:0]      mode_word_i = 0;
  logic [COL_W-1:0] start_col_i = 0;
  logic [COL_W-1:0] col_o;
  logic             col_valid_o, col_last_o, mode_illegal_o;
  logic [1:0]       cas_lat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(input logic [11:0] m, input int col, input int i, input int len);
    int off, base;
    off  = col % len;
    base = col - off;
    if (m[3]) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  task automatic load_mode(input logic [1:0] bank, input logic [11:0] w);
    mode_load_i = 1; mode_bank_i = bank; mode_word_i = w;
    @(negedge clk_i);
    mode_load_i = 0; mode_bank_i = 0;
  endtask

  task automatic start(input int col, input logic wr);
    start_i = 1; start_col_i = col[COL_W-1:0]; start_wr_i = wr;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic run_burst(input vec_t v, input string req);
    load_mode(2'd0, v.mode);
    start(int'(v.col), v.wr);
    for (int i = 0; i < int'(v.len); i++) begin
      check({req, " valid"}, int'(col_valid_o), 1);
      check({req, " col"}, int'(col_o), exp_col(v.mode, int'(v.col), i, int'(v.len)));
      check("R9 last flag", int'(col_last_o), int'(i == int'(v.len) - 1));
      @(negedge clk_i);
    end
    check("R9 valid drops after last", int'(col_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid at reset", int'(col_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 valid after reset", int'(col_valid_o), 0);
    check("R1 illegal after reset", int'(mode_illegal_o), 0);
    check("R1 cas after reset", int'(cas_lat_o), 2);
    start(9'h055, 1'b0);
    check("R1 default length 1 col", int'(col_o), 'h055);
    check("R1 default length 1 last", int'(col_last_o), 1);
    @(negedge clk_i);
    check("R1 default length 1 end", int'(col_valid_o), 0);

    for (int k = 0; k < 9; k++) begin
      string tag;
      tag = VECS[k].mode[9] ? "R12" : (VECS[k].mode[3] ? "R8" : (VECS[k].len == 1 ? "R6" : "R7"));
      run_burst(VECS[k], tag);
    end

    // R3 CAS 3 then R2 load to nonzero bank ignored
    load_mode(2'd0, 12'h033);
    check("R3 cas 3", int'(cas_lat_o), 3);
    load_mode(2'd1, 12'h043);
    check("R2 illegal unchanged", int'(mode_illegal_o), 0);
    check("R2 cas unchanged", int'(cas_lat_o), 3);
    load_mode(2'd2, 12'h020);
    check("R2 cas kept", int'(cas_lat_o), 3);
    start(9'h00C, 1'b0);
    for (int i = 0; i < 8; i++) begin
      check("R2 length kept col", int'(col_o), 'h00C + ((4 + i) % 8) - 4);
      @(negedge clk_i);
    end
    check("R2 length kept end", int'(col_valid_o), 0);

    // R4 reserved codes
    load_mode(2'd0, 12'h02F); check("R4 page+interleave", int'(mode_illegal_o), 1);
    check("R3 cas zero when illegal", int'(cas_lat_o), 0);
    // R5 start ignored while illegal
    start(9'h010, 1'b0);
    check("R5 start ignored", int'(col_valid_o), 0);
    @(negedge clk_i);
    check("R5 still idle", int'(col_valid_o), 0);
    load_mode(2'd0, 12'h043); check("R4 cas 100", int'(mode_illegal_o), 1);
    load_mode(2'd0, 12'h013); check("R4 cas 001", int'(mode_illegal_o), 1);
    load_mode(2'd0, 12'h0A3); check("R4 op 01", int'(mode_illegal_o), 1);
    load_mode(2'd0, 12'h423); check("R4 bit10", int'(mode_illegal_o), 1);
    load_mode(2'd0, 12'h824); check("R4 bit11 and bl 100", int'(mode_illegal_o), 1);
    load_mode(2'd0, 12'h025); check("R4 bl 101", int'(mode_illegal_o), 1);
    load_mode(2'd0, 12'h027); check("R4 full page seq legal", int'(mode_illegal_o), 0);

    // R10 full page wraps, R11 term
    start(9'h1FE, 1'b0);
    for (int i = 0; i < 4; i++) begin
      check("R10 page col", int'(col_o), ('h1FE + i) % 512);
      check("R10 no last", int'(col_last_o), 0);
      check("R10 valid", int'(col_valid_o), 1);
      if (i == 3) term_i = 1;
      @(negedge clk_i);
    end
    term_i = 0;
    check("R11 term stops", int'(col_valid_o), 0);

    // R11 term on fixed burst
    load_mode(2'd0, 12'h023);
    start(9'h030, 1'b0);
    check("R11 fixed col0", int'(col_o), 'h030);
    term_i = 1;
    @(negedge clk_i);
    term_i = 0;
    check("R11 fixed stops", int'(col_valid_o), 0);

    // R13 abort with new start
    start(9'h010, 1'b0);
    check("R13 first col", int'(col_o), 'h010);
    @(negedge clk_i);
    check("R13 second col", int'(col_o), 'h011);
    start(9'h025, 1'b0);
    for (int i = 0; i < 8; i++) begin
      check("R13 new burst col", int'(col_o), 'h020 + ((5 + i) % 8));
      check("R13 new burst last", int'(col_last_o), int'(i == 7));
      @(negedge clk_i);
    end
    check("R13 end", int'(col_valid_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule